// File: doc/BRIEF.md
# Gated Trace Stimulus Port Unit

This block is the register-bus front end of a software instrumentation trace path. Software writes a value to one of 32 stimulus port addresses. If that port's bit in a 32-bit enable mask is set, the value is tagged with the port number and queued in a small trace FIFO. If the bit is clear, the write is discarded without any trace.

Firmware learns whether the FIFO has room by reading any stimulus port. Bit 0 of the read data is 1 while the queue can take another entry. The enable mask is a read/write register on the same bus. A downstream packetizer empties the queue through a valid/ready drain port that carries the port number and the data.

The bus has no wait states. Reads are combinational on the address and reflect the FIFO state of the current cycle. Writes take effect at the clock edge that samples them.

Top module: `trace_stim_unit`

## Requirements
- R1: After reset the enable mask reads 0x00000000, `trc_valid` is 0, and a stimulus port read returns 1.
- R2: The enable mask register at 0xE0000E00 is 32 bits wide and read/write. A write replaces all bits, and a read returns the last value written.
- R3: A write to stimulus port n (address 0xE0000000 + 4*n, n = 0..31) while mask bit n is 1 and the FIFO is not full queues {port = n, data = write data}. The entry appears on `trc_valid`/`trc_port`/`trc_data` at the following edge.
- R4: A write to stimulus port n while mask bit n is 0 is discarded and queues nothing.
- R5: A read of any stimulus port returns 0 in bits 31:1. Bit 0 is 1 when the FIFO holds fewer than 8 entries and 0 when it holds 8.
- R6: A write to an enabled port while the FIFO is full and not draining in the same cycle is discarded. The 8 queued entries are not altered.
- R7: When the FIFO is full, an enabled-port write in the same cycle as a drain handshake is accepted.
- R8: Entries leave in arrival order, one per cycle in which `trc_valid` and `trc_ready` are both 1. While `trc_valid` is 1 and `trc_ready` is 0, `trc_port` and `trc_data` hold steady.
- R9: Reads of any other address return 0, and writes to them change neither the mask nor the FIFO. Stimulus addresses with nonzero bits 1:0, addresses 0xE0000080 and above, and 0xE0000E04 all count as other addresses.
- R10: A status read in the cycle right after the write that fills the FIFO already returns bit 0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not reading) |
| bus_ready | output | 1 | Access completes this cycle |
| trc_valid | output | 1 | FIFO head entry is available |
| trc_ready | input | 1 | Downstream takes the head entry |
| trc_port | output | 5 | Port number of head entry |
| trc_data | output | 32 | Data of head entry |

## Verification
The hardest situation to reach is a full FIFO that meets a write and a drain handshake in the same edge. The write must be accepted, and the entry it displaces must be the head and not the new item. The stimulus enables all ports and fills the queue with eight tagged writes. It then writes a ninth value with `trc_ready` low, which must vanish. Next it drives a write and the drain handshake in the same cycle. Draining the whole queue then shows the exact surviving order. The write that fills the queue is followed at once by a status read to catch a stale full flag.

// File: rtl/trace_stim_pkg.sv
// Shared constants and entry type for the trace stimulus unit.
// Assumes: port count is a power of two; data width equals the mask width.
package trace_stim_pkg;
    localparam int STIM_PORTS  = 32;
    localparam int STIM_DATA_W = 32;
    localparam int STIM_ADDR_W = 32;
    localparam int PORT_W      = $clog2(STIM_PORTS);

    typedef struct packed {
        logic [PORT_W-1:0]      port;
        logic [STIM_DATA_W-1:0] data;
    } trace_entry_t;

    localparam int ENTRY_W = $bits(trace_entry_t);
endpackage

// File: rtl/stim_addr_decode.sv
// Address decoder: finds stimulus port hits (word aligned, inside the port
// window) and the enable-mask register hit.
// Assumes: BASE_ADDR is word aligned.
module stim_addr_decode
    import trace_stim_pkg::*;
#(
    parameter logic [STIM_ADDR_W-1:0] BASE_ADDR  = 32'hE000_0000,
    parameter logic [STIM_ADDR_W-1:0] CTL_OFFSET = 32'h0000_0E00
) (
    input  logic [STIM_ADDR_W-1:0] addr,
    output logic                   port_hit,
    output logic [PORT_W-1:0]      port_idx,
    output logic                   ctl_hit
);
    localparam logic [STIM_ADDR_W-1:0] SPAN = STIM_ADDR_W'(STIM_PORTS * 4);
    localparam logic [STIM_ADDR_W-1:0] CTL_ADDR = BASE_ADDR + CTL_OFFSET;

    logic [STIM_ADDR_W-1:0] offset;

    // Decode the port window and the control register address.
    always_comb begin
        offset   = addr - BASE_ADDR;
        port_hit = (addr >= BASE_ADDR) && (offset < SPAN) && (offset[1:0] == 2'b00);
        port_idx = offset[PORT_W+1:2];
        ctl_hit  = (addr == CTL_ADDR);
    end
endmodule

// File: rtl/stim_enable_reg.sv
// Per-port enable mask register; a write replaces the whole mask.
// Assumes: mask width equals the port count.
module stim_enable_reg
    import trace_stim_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [STIM_PORTS-1:0] wdata,
    output logic [STIM_PORTS-1:0] mask
);
    // Hold the mask; clear on reset, load on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (wr)
            mask <= wdata;
    end
endmodule

// File: rtl/stim_fifo.sv
// Synchronous FIFO with first-word-fall-through output.
// It accepts a push when full if a pop happens in the same cycle, and it
// drops a push when full with no pop.
// Assumes: DEPTH >= 2.
module stim_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    output logic             full,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [W-1:0]     dout,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             pop, accept;

    // Handshake qualification.
    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        out_valid = (count != '0);
        pop       = out_valid && out_ready;
        accept    = push && (!full || pop);
        dout      = mem[rd_ptr];
        level     = count;
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (accept)
            mem[wr_ptr] <= din;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)    rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/trace_stim_unit.sv
// Top of the trace stimulus unit: bus decode, enable mask, gated enqueue
// into the trace FIFO, status and mask read-back, and the drain port.
// Assumes: zero-wait-state bus; read data is combinational on the address.
module trace_stim_unit
    import trace_stim_pkg::*;
#(
    parameter int                     FIFO_DEPTH = 8,
    parameter logic [STIM_ADDR_W-1:0] BASE_ADDR  = 32'hE000_0000,
    parameter logic [STIM_ADDR_W-1:0] CTL_OFFSET = 32'h0000_0E00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [STIM_ADDR_W-1:0] bus_addr,
    input  logic [STIM_DATA_W-1:0] bus_wdata,
    output logic [STIM_DATA_W-1:0] bus_rdata,
    output logic                   bus_ready,
    output logic                   trc_valid,
    input  logic                   trc_ready,
    output logic [PORT_W-1:0]      trc_port,
    output logic [STIM_DATA_W-1:0] trc_data
);
    localparam int LVL_W = $clog2(FIFO_DEPTH+1);

    logic                  port_hit, ctl_hit, fifo_full, push_req;
    logic [PORT_W-1:0]     port_idx;
    logic [STIM_PORTS-1:0] en_mask;
    logic [LVL_W-1:0]      fifo_level;
    trace_entry_t          in_entry, out_entry;

    stim_addr_decode #(.BASE_ADDR(BASE_ADDR), .CTL_OFFSET(CTL_OFFSET)) u_dec (
        .addr(bus_addr), .port_hit(port_hit), .port_idx(port_idx), .ctl_hit(ctl_hit)
    );

    stim_enable_reg u_en (
        .clk(clk), .rst_n(rst_n), .wr(bus_sel && bus_we && ctl_hit),
        .wdata(bus_wdata), .mask(en_mask)
    );

    // Gate the enqueue by the port's enable bit.
    always_comb begin
        push_req      = bus_sel && bus_we && port_hit && en_mask[port_idx];
        in_entry.port = port_idx;
        in_entry.data = bus_wdata;
    end

    stim_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_req), .din(in_entry),
        .full(fifo_full), .out_valid(trc_valid), .out_ready(trc_ready),
        .dout(out_entry), .level(fifo_level)
    );

    // Read mux: mask, port status, or zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (ctl_hit)       bus_rdata = en_mask;
            else if (port_hit) bus_rdata[0] = !fifo_full;
        end
        bus_ready = bus_sel;
        trc_port  = out_entry.port;
        trc_data  = out_entry.data;
    end
endmodule

// File: rtl/trace_stim_chk.sv
// Property checker for trace_stim_unit, attached with bind below.
// It decodes the bus address on its own and relates the bus, the mask and
// the FIFO level over time.
module trace_stim_chk
    import trace_stim_pkg::*;
#(
    parameter int                     DEPTH      = 8,
    parameter logic [STIM_ADDR_W-1:0] BASE_ADDR  = 32'hE000_0000,
    parameter logic [STIM_ADDR_W-1:0] CTL_OFFSET = 32'h0000_0E00
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_sel,
    input logic                   bus_we,
    input logic [STIM_ADDR_W-1:0] bus_addr,
    input logic [STIM_DATA_W-1:0] bus_wdata,
    input logic [STIM_DATA_W-1:0] bus_rdata,
    input logic                   trc_valid,
    input logic                   trc_ready,
    input logic [PORT_W-1:0]      trc_port,
    input logic [STIM_DATA_W-1:0] trc_data,
    input logic [STIM_PORTS-1:0]  en_mask,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int LVL_W = $clog2(DEPTH+1);
    logic [STIM_ADDR_W-1:0] off;
    logic is_port, is_ctl, undec_rd, dis_wr, en_wr;

    // Independent address classification.
    always_comb begin
        off      = bus_addr - BASE_ADDR;
        is_port  = (bus_addr >= BASE_ADDR) && (off < STIM_ADDR_W'(STIM_PORTS*4)) && (off[1:0] == 2'b00);
        is_ctl   = (bus_addr == BASE_ADDR + CTL_OFFSET);
        undec_rd = bus_sel && !bus_we && !is_port && !is_ctl;
        dis_wr   = bus_sel && bus_we && is_port && !en_mask[off[PORT_W+1:2]];
        en_wr    = bus_sel && bus_we && is_port && en_mask[off[PORT_W+1:2]] && (level != LVL_W'(DEPTH));
    end

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && is_ctl) |=> (en_mask == $past(bus_wdata)));

    assert_enqueue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> trc_valid);

    assert_disabled_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_wr && !(trc_valid && trc_ready)) |=> (level == $past(level)));

    assert_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && is_port) |->
            (bus_rdata[31:1] == '0 && bus_rdata[0] == (level != LVL_W'(DEPTH))));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_valid && !trc_ready) |=> (trc_valid && $stable(trc_port) && $stable(trc_data)));

    assert_undecoded_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        undec_rd |-> (bus_rdata == '0));
endmodule

bind trace_stim_unit trace_stim_chk #(
    .DEPTH(FIFO_DEPTH), .BASE_ADDR(BASE_ADDR), .CTL_OFFSET(CTL_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trc_valid(trc_valid), .trc_ready(trc_ready), .trc_port(trc_port),
    .trc_data(trc_data), .en_mask(en_mask), .level(fifo_level)
);

// File: tb/sim_trace_stim_unit.sv
module sim_trace_stim_unit;
    localparam logic [31:0] BASE = 32'hE000_0000;
    localparam logic [31:0] CTL  = 32'hE000_0E00;

    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0, trc_ready = 0;
    logic [31:0] bus_addr = 0, bus_wdata = 0;
    logic [31:0] bus_rdata, trc_data;
    logic        bus_ready, trc_valid;
    logic [4:0]  trc_port;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    trace_stim_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .trc_valid(trc_valid), .trc_ready(trc_ready),
        .trc_port(trc_port), .trc_data(trc_data)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    // Sample the head, then pop it when valid.
    task automatic drain(output logic v, output logic [4:0] p, output logic [31:0] d);
        @(negedge clk);
        #1 v = trc_valid; p = trc_port; d = trc_data;
        if (v) trc_ready = 1;
        @(negedge clk);
        trc_ready = 0;
    endtask

    function automatic logic [31:0] pat(int p);
        return 32'h1357_0000 + 32'(p) * 32'h0001_0101;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, d;
        logic [4:0]  p;
        logic        v;
        logic [31:0] mask;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        #1 chk("R1 valid", {31'b0, trc_valid}, 0);
        rd(CTL, r);            chk("R1 mask", r, 0);
        rd(BASE, r);           chk("R1 status", r, 1);

        // R5: every port reads status 1 when empty
        for (int i = 0; i < 32; i++) begin
            rd(BASE + 32'(4*i), r); chk("R5 empty status", r, 1);
        end

        // R2: mask read/write
        wr(CTL, 32'hA5A5_0F0F); rd(CTL, r); chk("R2 mask", r, 32'hA5A5_0F0F);
        mask = 32'h6996_C33C;
        wr(CTL, mask);          rd(CTL, r); chk("R2 mask", r, mask);

        // R3/R4: sweep all ports under a mixed mask
        for (int i = 0; i < 32; i++) begin
            wr(BASE + 32'(4*i), pat(i));
            drain(v, p, d);
            chk(mask[i] ? "R3 enqueued" : "R4 dropped", {31'b0, v}, {31'b0, mask[i]});
            if (mask[i]) begin
                chk("R3 port", {27'b0, p}, 32'(i));
                chk("R3 data", d, pat(i));
            end
        end

        // R6/R10/R7: fill, overflow, simultaneous push and pop
        wr(CTL, 32'hFFFF_FFFF);
        for (int i = 0; i < 7; i++) wr(BASE + 32'(4*i), 32'hC0DE_0000 | 32'(i));
        rd(BASE + 32'h7C, r); chk("R5 seven held", r, 1);
        // R10: fill write followed at once by a status read
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = BASE + 32'h1C; bus_wdata = 32'hC0DE_0007;
        @(negedge clk);
        bus_we = 0; bus_addr = BASE + 32'h40;
        #2 chk("R10 full next cycle", bus_rdata, 0);
        @(negedge clk); bus_sel = 0;
        // R6: overflow write dropped
        wr(BASE + 32'h24, 32'hDEAD_0009);
        rd(BASE, r); chk("R6 still full", r, 0);
        #1 chk("R8 head port", {27'b0, trc_port}, 0);
        // R7: write and pop in the same cycle while full
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = BASE + 32'h28; bus_wdata = 32'hC0DE_000A;
        trc_ready = 1;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; trc_ready = 0;
        rd(BASE, r); chk("R7 accepted, full", r, 0);
        for (int i = 1; i <= 8; i++) begin
            drain(v, p, d);
            chk("R8 order valid", {31'b0, v}, 1);
            chk("R6/R7 port", {27'b0, p}, (i == 8) ? 32'd10 : 32'(i));
            chk("R6/R7 data", d, 32'hC0DE_0000 | ((i == 8) ? 32'd10 : 32'(i)));
        end
        drain(v, p, d); chk("R6 empty after drain", {31'b0, v}, 0);

        // R8: head holds while not ready
        wr(BASE + 32'h0C, 32'h0000_AAAA);
        wr(BASE + 32'h10, 32'h0000_BBBB);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1 chk("R8 hold port", {27'b0, trc_port}, 3);
            chk("R8 hold data", trc_data, 32'h0000_AAAA);
        end
        drain(v, p, d); drain(v, p, d);
        chk("R8 second entry", d, 32'h0000_BBBB);

        // R9: undecoded addresses
        wr(BASE + 32'h80, 1); wr(BASE + 32'h02, 2); wr(CTL + 4, 0); wr(32'h1000_0000, 3);
        #1 chk("R9 no enqueue", {31'b0, trc_valid}, 0);
        rd(CTL, r);               chk("R9 mask untouched", r, 32'hFFFF_FFFF);
        rd(BASE + 32'h80, r);     chk("R9 read zero", r, 0);
        rd(BASE + 32'h01, r);     chk("R9 misaligned zero", r, 0);
        rd(CTL + 4, r);           chk("R9 after ctl zero", r, 0);
        rd(32'h1000_0000, r);     chk("R9 far zero", r, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule